// File: doc/BRIEF.md
# Half-Word Host Bus Pairing Adapter

This block sits between a host bus and an internal 32-bit register port. A strap input is sampled while reset is held, and it selects between two modes. In full-width mode, each host access becomes exactly one internal access. In half-width mode the host moves 16 bits per access, so a DWORD needs two accesses, one to each half, and `hst_addr[1]` selects the half. The adapter pairs these two accesses. A write becomes one internal 32-bit write when the second half arrives. A read performs one internal 32-bit read on the first half and serves the other half from a latched copy, so a register with read side effects is read only once.

The two halves may come in either order. If the host writes the same half twice in a row, the second write is dropped. If it reads the same half twice in a row, that read returns zero and the read pairing restarts. A change of the DWORD address, or an access of the other direction, abandons a pending pair.

Host requests use valid/ready. `hst_ready` follows `reg_ready` whenever the access needs the internal port. Otherwise the request is taken at once. While `hst_valid` is high and `hst_ready` is low, the host must hold the request stable. Read responses appear on `rsp_valid` one cycle after acceptance and cannot be back-pressured.

Top module: `bha_host_adapter`

## Requirements
- R1: In full-width mode (`hw_cfg[2]`=1), every host request drives `reg_valid` in the same cycle, with the host address, data and direction unchanged. The read response is `reg_rdata` in full, on `rsp_valid` one cycle after acceptance.
- R2: In half-width mode, the first half of a write is accepted at once and makes no internal access.
- R3: In half-width mode, a write to the opposite half of the same DWORD makes one internal write at the DWORD-aligned address. Bits [15:0] come from the `hst_addr[1]`=0 access and bits [31:16] from the `hst_addr[1]`=1 access, whichever came first.
- R4: A write to the same half that is already pending is dropped: no internal access, and the buffered data is kept.
- R5: In half-width mode, the first half of a read makes one internal read. The response carries the selected half in `rsp_data[15:0]`, with `rsp_data[31:16]`=0.
- R6: A read of the opposite half of a pending read pair is served from the latch, with no internal access.
- R7: A repeated read of the same pending half returns `rsp_data`=0 with no internal access, and it clears the pairing. The next read is a first half.
- R8: An access whose `hst_addr[AW-1:2]` differs from the pending pair abandons that pair and is treated as a first half.
- R9: An accepted access of the other direction abandons a pending pair.
- R10: `hst_upper_oe` is never high in half-width mode. In full-width mode it equals `rsp_valid`.
- R11: `hw_cfg[2]` holds the strap value sampled during reset, and all other bits of `hw_cfg` are 0.
- R12: While an access needs the internal port and `reg_ready` is 0, `hst_ready` is 0 and no access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| strap_bus32 | input | 1 | 1 = full-width mode, 0 = half-width mode |
| hst_valid | input | 1 | Host request valid |
| hst_ready | output | 1 | Host request accepted |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | AW | Host byte address; bit 1 selects the half |
| hst_wdata | input | 32 | Write data; only [15:0] is used in half-width mode |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| hst_upper_oe | output | 1 | Drive enable for the upper 16 data lanes |
| reg_valid | output | 1 | Internal access request |
| reg_ready | input | 1 | Internal access accepted |
| reg_we | output | 1 | Internal write strobe |
| reg_addr | output | AW | Internal address |
| reg_wdata | output | 32 | Internal write data |
| reg_rdata | input | 32 | Internal read data, valid on handshake |
| hw_cfg | output | 32 | Configuration word, strap in bit 2 |

## Verification
The hardest states to reach from the ports are pairs that break part-way through: a pending write interrupted by a read, a DWORD change, or a duplicate half. The directed tasks build these states deliberately. Each task sends a first half, then the disrupting access, then a further half. The bench counts internal handshakes to prove that no spurious write left the block, and it checks which buffered data reached the completing write. Back-pressure is reached by holding `reg_ready` low across a first-half read.

// File: rtl/bha_pkg.sv
package bha_pkg;
  localparam int CFG_BUS32_BIT = 2;

  typedef enum logic [1:0] {
    ACT_DIRECT = 2'd0,
    ACT_FIRST  = 2'd1,
    ACT_SECOND = 2'd2,
    ACT_SAME   = 2'd3
  } act_e;
endpackage

// File: rtl/bha_pair_track.sv
module bha_pair_track #(
  parameter int DW            = 6,
  parameter bit SAME_RESTARTS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc,
  input  logic          half,
  input  logic [DW-1:0] dw,
  output logic          is_second,
  output logic          is_same
);
  logic          pend_q;
  logic          half_q;
  logic [DW-1:0] dw_q;
  logic          hit;
  logic          same_keep;

  assign hit       = pend_q && (dw == dw_q);
  assign is_second = hit && (half != half_q);
  assign is_same   = hit && (half == half_q);

  generate
    if (SAME_RESTARTS) begin : g_restart
      assign same_keep = 1'b0;
    end else begin : g_keep
      assign same_keep = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      half_q <= 1'b0;
      dw_q   <= '0;
    end else if (clr) begin
      pend_q <= 1'b0;
    end else if (acc) begin
      if (is_second) begin
        pend_q <= 1'b0;
      end else if (is_same) begin
        pend_q <= same_keep;
      end else begin
        pend_q <= 1'b1;
        half_q <= half;
        dw_q   <= dw;
      end
    end
  end
endmodule

// File: rtl/bha_wr_merge.sv
module bha_wr_merge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        in_half,
  input  logic [15:0] in_word,
  output logic [31:0] merged
);
  logic [15:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    buf_q <= '0;
    else if (load) buf_q <= in_word;
  end

  assign merged = in_half ? {in_word, buf_q} : {buf_q, in_word};
endmodule

// File: rtl/bha_rd_latch.sv
module bha_rd_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] din,
  input  logic        sel_half,
  input  logic        use_latch,
  output logic [15:0] half_out
);
  logic [31:0] lat_q;
  logic [31:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (load) lat_q <= din;
  end

  assign src      = use_latch ? lat_q : din;
  assign half_out = sel_half ? src[31:16] : src[15:0];
endmodule

// File: rtl/bha_host_adapter.sv
module bha_host_adapter
  import bha_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_bus32,
  input  logic          hst_valid,
  output logic          hst_ready,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          hst_upper_oe,
  output logic          reg_valid,
  input  logic          reg_ready,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [31:0]   reg_wdata,
  input  logic [31:0]   reg_rdata,
  output logic [31:0]   hw_cfg
);
  localparam int DW = AW - 2;

  logic          bus32_q;
  logic          mode16;
  logic          half;
  logic [DW-1:0] dw;
  logic          wr_second, wr_same, rd_second, rd_same;
  act_e          act;
  logic          need_reg;
  logic          acc, wr_acc, rd_acc;
  logic [31:0]   merged;
  logic [15:0]   rd_half;
  logic          rsp_valid_q;
  logic [31:0]   rsp_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus32_q <= strap_bus32;
  end

  assign mode16 = ~bus32_q;
  assign half   = hst_addr[1];
  assign dw     = hst_addr[AW-1:2];

  always_comb begin
    if (!mode16)                act = ACT_DIRECT;
    else if (hst_we && wr_second) act = ACT_SECOND;
    else if (hst_we && wr_same)   act = ACT_SAME;
    else if (!hst_we && rd_second) act = ACT_SECOND;
    else if (!hst_we && rd_same)   act = ACT_SAME;
    else                        act = ACT_FIRST;
  end

  assign need_reg = (act == ACT_DIRECT) ||
                    (hst_we && act == ACT_SECOND) ||
                    (!hst_we && act == ACT_FIRST);

  assign reg_valid = hst_valid && need_reg;
  assign hst_ready = need_reg ? reg_ready : 1'b1;
  assign acc       = hst_valid && hst_ready;
  assign wr_acc    = acc && hst_we && mode16;
  assign rd_acc    = acc && !hst_we && mode16;

  bha_pair_track #(.DW(DW), .SAME_RESTARTS(1'b0)) u_wr_trk (
    .clk(clk), .rst_n(rst_n), .clr(rd_acc), .acc(wr_acc),
    .half(half), .dw(dw), .is_second(wr_second), .is_same(wr_same)
  );

  bha_pair_track #(.DW(DW), .SAME_RESTARTS(1'b1)) u_rd_trk (
    .clk(clk), .rst_n(rst_n), .clr(wr_acc), .acc(rd_acc),
    .half(half), .dw(dw), .is_second(rd_second), .is_same(rd_same)
  );

  bha_wr_merge u_merge (
    .clk(clk), .rst_n(rst_n), .load(wr_acc && act == ACT_FIRST),
    .in_half(half), .in_word(hst_wdata[15:0]), .merged(merged)
  );

  bha_rd_latch u_rlat (
    .clk(clk), .rst_n(rst_n), .load(rd_acc && act == ACT_FIRST),
    .din(reg_rdata), .sel_half(half), .use_latch(act == ACT_SECOND),
    .half_out(rd_half)
  );

  assign reg_we    = hst_we;
  assign reg_addr  = mode16 ? {dw, 2'b00} : hst_addr;
  assign reg_wdata = mode16 ? merged : hst_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= acc && !hst_we;
      if (acc && !hst_we) begin
        if (!mode16)              rsp_data_q <= reg_rdata;
        else if (act == ACT_SAME) rsp_data_q <= '0;
        else                      rsp_data_q <= {16'h0000, rd_half};
      end
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign hst_upper_oe = rsp_valid_q && bus32_q;

  always_comb begin
    hw_cfg                = '0;
    hw_cfg[CFG_BUS32_BIT] = bus32_q;
  end
endmodule

// File: rtl/bha_host_adapter_chk.sv
module bha_host_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] hw_cfg,
  input logic        hst_valid,
  input logic        hst_ready,
  input logic        hst_we,
  input logic        reg_valid,
  input logic        reg_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        hst_upper_oe
);
  p_upper_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_cfg[2] |-> !hst_upper_oe);

  p_oe_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_cfg[2] |-> (hst_upper_oe == rsp_valid));

  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && hst_ready && !hst_we) |=> rsp_valid);

  p_rsp_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(hst_valid && hst_ready && !hst_we));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_cfg[2] && rsp_valid) |-> (rsp_data[31:16] == 16'h0000));

  p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_cfg[2] && hst_valid) |-> reg_valid);

  p_backpressure_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |-> !hst_ready);
endmodule

bind bha_host_adapter bha_host_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_cfg(hw_cfg), .hst_valid(hst_valid),
  .hst_ready(hst_ready), .hst_we(hst_we), .reg_valid(reg_valid),
  .reg_ready(reg_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .hst_upper_oe(hst_upper_oe)
);

// File: tb/sim_bha_host_adapter.sv
`timescale 1ns/1ps
module sim_bha_host_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_bus32 = 1'b1;
  logic        hst_valid = 1'b0;
  logic        hst_ready;
  logic        hst_we = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        hst_upper_oe;
  logic        reg_valid;
  logic        reg_ready = 1'b1;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] hw_cfg;

  int n_tests = 0;
  int n_fail  = 0;
  int n_acc   = 0;
  logic        last_we;
  logic [7:0]  last_addr;
  logic [31:0] last_wdata;
  logic        got_rv, got_oe;
  logic [31:0] got_rd;

  always #5 clk = ~clk;

  function automatic logic [31:0] model(input logic [7:0] a);
    return {a, 8'hC3, 8'h5A, ~a};
  endfunction

  assign reg_rdata = model(reg_addr);

  bha_host_adapter #(.AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_bus32(strap_bus32),
    .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .hst_upper_oe(hst_upper_oe), .reg_valid(reg_valid),
    .reg_ready(reg_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_cfg(hw_cfg)
  );

  always @(posedge clk) begin
    if (reg_valid && reg_ready) begin
      n_acc      = n_acc + 1;
      last_we    = reg_we;
      last_addr  = reg_addr;
      last_wdata = reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic bus32);
    @(negedge clk);
    rst_n = 1'b0; strap_bus32 = bus32; hst_valid = 1'b0; reg_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    strap_bus32 = ~bus32;
    @(negedge clk);
  endtask

  task automatic host_acc(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_valid = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
    #1;
    while (!hst_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    hst_valid = 1'b0;
    got_rv = rsp_valid; got_rd = rsp_data; got_oe = hst_upper_oe;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    chk(hw_cfg == 32'h4, "R11 cfg full", hw_cfg, 32'h4);
    chk(!rsp_valid && !hst_upper_oe, "R10 idle after reset", {rsp_valid, hst_upper_oe}, 0);
    do_reset(1'b0);
    chk(hw_cfg == 32'h0, "R11 cfg half", hw_cfg, 32'h0);
  endtask

  task automatic t_full_width();
    int c;
    do_reset(1'b1);
    c = n_acc;
    host_acc(1'b1, 8'h15, 32'hDEADBEEF);
    chk(n_acc == c + 1, "R1 write count", n_acc, c + 1);
    chk(last_addr == 8'h15 && last_we, "R1 write addr", last_addr, 8'h15);
    chk(last_wdata == 32'hDEADBEEF, "R1 write data", last_wdata, 32'hDEADBEEF);
    host_acc(1'b0, 8'h20, 0);
    chk(got_rv && got_rd == model(8'h20), "R1 read data", got_rd, model(8'h20));
    chk(got_oe, "R10 upper oe full", got_oe, 1);
  endtask

  task automatic t_wr_pair();
    int c;
    do_reset(1'b0);
    c = n_acc;
    host_acc(1'b1, 8'h10, 32'hFFFF1111);
    chk(n_acc == c, "R2 first half silent", n_acc, c);
    host_acc(1'b1, 8'h12, 32'h00002222);
    chk(n_acc == c + 1 && last_addr == 8'h10, "R3 lo-hi addr", last_addr, 8'h10);
    chk(last_wdata == 32'h22221111, "R3 lo-hi data", last_wdata, 32'h22221111);
    host_acc(1'b1, 8'h32, 32'h0000AAAA);
    host_acc(1'b1, 8'h30, 32'h0000BBBB);
    chk(n_acc == c + 2 && last_wdata == 32'hAAAABBBB, "R3 hi-lo data", last_wdata, 32'hAAAABBBB);
  endtask

  task automatic t_wr_same();
    int c;
    do_reset(1'b0);
    c = n_acc;
    host_acc(1'b1, 8'h40, 32'h1234);
    host_acc(1'b1, 8'h40, 32'h9999);
    chk(n_acc == c, "R4 duplicate dropped", n_acc, c);
    host_acc(1'b1, 8'h42, 32'h5678);
    chk(last_wdata == 32'h56781234, "R4 first data kept", last_wdata, 32'h56781234);
  endtask

  task automatic t_rd_pair();
    int c;
    logic [31:0] m;
    do_reset(1'b0);
    m = model(8'h50);
    c = n_acc;
    host_acc(1'b0, 8'h52, 0);
    chk(n_acc == c + 1, "R5 one internal read", n_acc, c + 1);
    chk(got_rv && got_rd == {16'h0, m[31:16]}, "R5 high half", got_rd, {16'h0, m[31:16]});
    chk(!got_oe, "R10 upper oe half", got_oe, 0);
    host_acc(1'b0, 8'h50, 0);
    chk(n_acc == c + 1, "R6 no second read", n_acc, c + 1);
    chk(got_rv && got_rd == {16'h0, m[15:0]}, "R6 latched low", got_rd, {16'h0, m[15:0]});
  endtask

  task automatic t_rd_same();
    int c;
    logic [31:0] m;
    do_reset(1'b0);
    m = model(8'h60);
    c = n_acc;
    host_acc(1'b0, 8'h60, 0);
    host_acc(1'b0, 8'h60, 0);
    chk(n_acc == c + 1, "R7 no access on repeat", n_acc, c + 1);
    chk(got_rv && got_rd == 0, "R7 zero data", got_rd, 0);
    host_acc(1'b0, 8'h62, 0);
    chk(n_acc == c + 2, "R7 new pair reads", n_acc, c + 2);
    chk(got_rd == {16'h0, m[31:16]}, "R7 new pair data", got_rd, {16'h0, m[31:16]});
  endtask

  task automatic t_dw_change();
    int c;
    do_reset(1'b0);
    c = n_acc;
    host_acc(1'b1, 8'h70, 32'h0101);
    host_acc(1'b1, 8'h76, 32'h0202);
    chk(n_acc == c, "R8 new dword no write", n_acc, c);
    host_acc(1'b1, 8'h74, 32'h0303);
    chk(n_acc == c + 1 && last_addr == 8'h74, "R8 addr", last_addr, 8'h74);
    chk(last_wdata == 32'h02020303, "R8 data", last_wdata, 32'h02020303);
  endtask

  task automatic t_kind_switch();
    int c;
    do_reset(1'b0);
    host_acc(1'b1, 8'h80, 32'hAAAA);
    host_acc(1'b0, 8'h90, 0);
    c = n_acc;
    host_acc(1'b1, 8'h82, 32'hBBBB);
    chk(n_acc == c, "R9 pair abandoned", n_acc, c);
    host_acc(1'b1, 8'h80, 32'hCCCC);
    chk(n_acc == c + 1 && last_wdata == 32'hBBBBCCCC, "R9 restart data", last_wdata, 32'hBBBBCCCC);
  endtask

  task automatic t_backpressure();
    int c;
    do_reset(1'b0);
    c = n_acc;
    @(negedge clk);
    reg_ready = 1'b0;
    hst_valid = 1'b1; hst_we = 1'b0; hst_addr = 8'hA0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!hst_ready, "R12 stalled", hst_ready, 0);
      @(negedge clk);
    end
    chk(n_acc == c && !rsp_valid, "R12 nothing done", n_acc, c);
    reg_ready = 1'b1;
    @(negedge clk);
    hst_valid = 1'b0;
    chk(n_acc == c + 1 && rsp_valid, "R12 completes", n_acc, c + 1);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_full_width();
    t_wr_pair();
    t_wr_same();
    t_rd_pair();
    t_rd_same();
    t_dw_change();
    t_kind_switch();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule